// File: doc/BRIEF.md
# Frame Attestation Command Controller

This block carries out one configuration-attestation command at a time. Its storage is a buffer that holds exactly one configuration frame of 81 words of 32 bits. There are three commands. A frame write collects a frame of payload and sends it to a configuration write port. A frame readback asks a configuration read port for one frame by number. A checksum request closes the running keyed MAC session and returns its tag.

During a readback, each word that comes back is written to the frame buffer and also pushed into an output FIFO, so the verifier can receive the raw frame. Once the frame is complete, the buffered words are packed into 128-bit blocks and handed to an external MAC engine as one update step per frame.

A MAC session opens by itself on the first readback that finds no session running: an init handshake comes first. The session then stays open across any number of readbacks, which may come in any order and may repeat. Only a checksum command closes it.

Top module: `frame_attest_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `rejBusy` and `sessionOpen` are low, every outgoing valid is low and the output FIFO is empty.
- R2: Command op 0 (write) takes the next 81 words presented with `payValid`, in order, into the frame buffer. It then sends those words unchanged, word 0 first, on `cfgWrData`. Word 0 carries the target configuration address. The command ends with `done` and status 0.
- R3: Command op 1 (readback) with a frame number in range issues one read request that carries that number on `cfgRdFrame`. It accepts exactly 81 returned words and pushes each of them into the output FIFO in arrival order.
- R4: After the 81 words of a readback, the frame is sent as 21 MAC update blocks. Block b holds frame word 4b+k in bits [32k+31:32k], and lanes past word 80 are zero. `macUpdLast` is high only on block 20.
- R5: A readback that finds no open session performs exactly one init handshake before its read request and then sets `sessionOpen`. A readback inside an open session performs no init.
- R6: Command op 2 (checksum) with an open session performs one finalize handshake. It then waits for `macTagValid`, returns that tag on `rspTag` with status 0 and clears `sessionOpen`.
- R7: A checksum command with no open session performs no finalize and completes with status 1.
- R8: A readback frame number above 28487 completes with status 2. It issues no read request and no MAC activity. Frame 28487 itself is accepted.
- R9: A command presented while `busy` is high is not executed and not queued. `rejBusy` pulses high in the following cycle.
- R10: Command op 3 completes with status 3 and has no other effect.
- R11: On the write, read-request, init, update and finalize outputs, at most one valid is high at a time. An update or write word held without ready keeps its valid high and its data unchanged.
- R12: Every readback adds its own complete 21-block update sequence, also when the same frame number is read again within a session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 0 write, 1 readback, 2 checksum, 3 reserved |
| cmdFrame | input | 15 | Frame number for readback |
| payValid | input | 1 | Payload word strobe during a write |
| payData | input | 32 | Payload word |
| busy | output | 1 | A command is in progress |
| rejBusy | output | 1 | Pulse: previous-cycle command was refused |
| done | output | 1 | One-cycle completion pulse |
| rspStatus | output | 2 | 0 ok, 1 no session, 2 frame out of range, 3 bad op; valid with done |
| rspTag | output | 128 | Last returned MAC tag |
| sessionOpen | output | 1 | MAC session running |
| cfgWrValid | output | 1 | Configuration write word valid |
| cfgWrData | output | 32 | Configuration write word |
| cfgWrReady | input | 1 | Configuration write ready |
| cfgRdReqValid | output | 1 | Frame read request valid |
| cfgRdFrame | output | 15 | Frame number requested |
| cfgRdReqReady | input | 1 | Read request accepted |
| cfgRdValid | input | 1 | Returned frame word valid |
| cfgRdData | input | 32 | Returned frame word |
| cfgRdReady | output | 1 | Ready for a returned word |
| fifoValid | output | 1 | Output FIFO not empty |
| fifoData | output | 32 | Output FIFO head word |
| fifoReady | input | 1 | Output FIFO pop |
| macInitValid | output | 1 | MAC init request |
| macInitReady | input | 1 | MAC init accepted |
| macUpdValid | output | 1 | MAC update block valid |
| macUpdData | output | 128 | MAC update block |
| macUpdLast | output | 1 | Final (partial) block of a frame |
| macUpdReady | input | 1 | MAC update accepted |
| macFinValid | output | 1 | MAC finalize request |
| macFinReady | input | 1 | Finalize accepted |
| macTagValid | input | 1 | Tag returned |
| macTag | input | 128 | Tag value |

## Verification
The hardest state to reach from the ports is a session that spans several commands. Reaching it takes a readback that opens the session, more readbacks of random and repeated frame numbers with no further init, a refused command arriving in the middle of a readback, and a checksum that closes the session, after which the next readback must init again. The stimulus runs exactly that chain. The configuration and MAC side models answer with ready, valid and tag delays drawn from a seeded generator, so update blocks and write words are often held by backpressure in the middle of a frame. The range boundary is driven directly at frames 28487 and 28488.

// File: rtl/fac_pkg.sv
package fac_pkg;
  localparam int WORD_W      = 32;
  localparam int FRAME_WORDS = 81;
  localparam int BLK_W       = 128;
  localparam int FRAME_ID_W  = 15;
  localparam int MAX_FRAME   = 28487;
  localparam int FIFO_DEPTH  = 128;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_SUM   = 2'd2,
    OP_RSVD  = 2'd3
  } opE;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_NOSESS = 2'd1,
    ST_RANGE  = 2'd2,
    ST_BADOP  = 2'd3
  } statusE;

  typedef struct packed {
    logic clrCnt;
    logic incWord;
    logic wrPay;
    logic wrRd;
    logic pushFifo;
    logic incBlk;
    logic latchFrame;
    logic capTag;
  } strobeT;
endpackage

// File: rtl/fac_datapath.sv
module fac_datapath
  import fac_pkg::*;
#(
  parameter int WORD_W      = fac_pkg::WORD_W,
  parameter int FRAME_WORDS = fac_pkg::FRAME_WORDS,
  parameter int BLK_W       = fac_pkg::BLK_W,
  parameter int FRAME_ID_W  = fac_pkg::FRAME_ID_W,
  parameter int FIFO_DEPTH  = fac_pkg::FIFO_DEPTH
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                stb,
  input  logic [FRAME_ID_W-1:0] cmdFrame,
  input  logic [WORD_W-1:0]     payData,
  input  logic [WORD_W-1:0]     cfgRdData,
  input  logic [BLK_W-1:0]      macTag,
  input  logic                  fifoReady,
  output logic                  wordLast,
  output logic                  blkLast,
  output logic                  fifoFull,
  output logic [WORD_W-1:0]     cfgWrData,
  output logic [BLK_W-1:0]      macUpdData,
  output logic [FRAME_ID_W-1:0] frameReg,
  output logic [BLK_W-1:0]      tagReg,
  output logic                  fifoValid,
  output logic [WORD_W-1:0]     fifoData
);
  localparam int WPB       = BLK_W / WORD_W;
  localparam int NUM_BLK   = (FRAME_WORDS + WPB - 1) / WPB;
  localparam int ADDR_W    = $clog2(FRAME_WORDS);
  localparam int BLK_CNT_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
  localparam int IDX_W     = $clog2(NUM_BLK * WPB);
  localparam int PTR_W     = $clog2(FIFO_DEPTH);

  logic [WORD_W-1:0]    frameBuf [FRAME_WORDS];
  logic [ADDR_W-1:0]    wordCnt;
  logic [BLK_CNT_W-1:0] blkCnt;

  // word and block counters; a clear wins over an increment
  always_ff @(posedge clk) begin
    if (!rstN || stb.clrCnt) begin
      wordCnt <= '0;
      blkCnt  <= '0;
    end else begin
      if (stb.incWord) wordCnt <= wordCnt + 1'b1;
      if (stb.incBlk)  blkCnt  <= blkCnt + 1'b1;
    end
  end

  assign wordLast = (wordCnt == ADDR_W'(FRAME_WORDS - 1));
  assign blkLast  = (blkCnt == BLK_CNT_W'(NUM_BLK - 1));

  // single-frame buffer, filled either from payload or from readback
  always_ff @(posedge clk) begin
    if (stb.wrPay)     frameBuf[wordCnt] <= payData;
    else if (stb.wrRd) frameBuf[wordCnt] <= cfgRdData;
  end

  assign cfgWrData = frameBuf[wordCnt];

  // block packer: one lane per word of a MAC block, zero past frame end
  for (genvar k = 0; k < WPB; k++) begin : g_lane
    logic [IDX_W-1:0] idx;
    assign idx = IDX_W'(blkCnt) * IDX_W'(WPB) + IDX_W'(k);
    assign macUpdData[k*WORD_W +: WORD_W] =
      (idx < IDX_W'(FRAME_WORDS)) ? frameBuf[idx[ADDR_W-1:0]] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg <= '0;
      tagReg   <= '0;
    end else begin
      if (stb.latchFrame) frameReg <= cmdFrame;
      if (stb.capTag)     tagReg   <= macTag;
    end
  end

  // output FIFO of read-back words
  logic [WORD_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [PTR_W:0]    fifoCnt;
  logic              popFifo;

  assign popFifo   = fifoValid && fifoReady;
  assign fifoValid = (fifoCnt != '0);
  assign fifoFull  = (fifoCnt == (PTR_W+1)'(FIFO_DEPTH));
  assign fifoData  = fifoMem[rdPtr];

  always_ff @(posedge clk) begin
    if (stb.pushFifo) fifoMem[wrPtr] <= cfgRdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fifoCnt <= '0;
    end else begin
      if (stb.pushFifo) wrPtr <= wrPtr + 1'b1;
      if (popFifo)      rdPtr <= rdPtr + 1'b1;
      case ({stb.pushFifo, popFifo})
        2'b10:   fifoCnt <= fifoCnt + 1'b1;
        2'b01:   fifoCnt <= fifoCnt - 1'b1;
        default: fifoCnt <= fifoCnt;
      endcase
    end
  end
endmodule

// File: rtl/fac_control.sv
module fac_control
  import fac_pkg::*;
#(
  parameter int FRAME_ID_W = fac_pkg::FRAME_ID_W,
  parameter int MAX_FRAME  = fac_pkg::MAX_FRAME
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [1:0]            cmdOp,
  input  logic [FRAME_ID_W-1:0] cmdFrame,
  input  logic                  payValid,
  input  logic                  wordLast,
  input  logic                  blkLast,
  input  logic                  fifoFull,
  input  logic                  cfgWrReady,
  input  logic                  cfgRdReqReady,
  input  logic                  cfgRdValid,
  input  logic                  macInitReady,
  input  logic                  macUpdReady,
  input  logic                  macFinReady,
  input  logic                  macTagValid,
  output strobeT                stb,
  output logic                  busy,
  output logic                  rejBusy,
  output logic                  done,
  output logic [1:0]            rspStatus,
  output logic                  sessionOpen,
  output logic                  cfgWrValid,
  output logic                  cfgRdReqValid,
  output logic                  cfgRdReady,
  output logic                  macInitValid,
  output logic                  macUpdValid,
  output logic                  macUpdLast,
  output logic                  macFinValid
);
  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_WRITE, S_INIT, S_RDREQ, S_RDDATA, S_UPD, S_FIN, S_TAG, S_RESP
  } stateE;

  stateE  state, stateNxt;
  statusE statusReg, statusNxt;
  logic   sessNxt;

  always_comb begin
    stb       = '0;
    stateNxt  = state;
    statusNxt = statusReg;
    sessNxt   = sessionOpen;
    case (state)
      S_IDLE: if (cmdValid) begin
        stb.clrCnt     = 1'b1;
        stb.latchFrame = 1'b1;
        statusNxt      = ST_OK;
        case (opE'(cmdOp))
          OP_WRITE: stateNxt = S_LOAD;
          OP_READ: begin
            if (cmdFrame > FRAME_ID_W'(MAX_FRAME)) begin
              statusNxt = ST_RANGE;
              stateNxt  = S_RESP;
            end else begin
              stateNxt = sessionOpen ? S_RDREQ : S_INIT;
            end
          end
          OP_SUM: begin
            if (sessionOpen) stateNxt = S_FIN;
            else begin
              statusNxt = ST_NOSESS;
              stateNxt  = S_RESP;
            end
          end
          default: begin
            statusNxt = ST_BADOP;
            stateNxt  = S_RESP;
          end
        endcase
      end
      S_LOAD: if (payValid) begin
        stb.wrPay   = 1'b1;
        stb.incWord = 1'b1;
        if (wordLast) begin
          stb.clrCnt = 1'b1;
          stateNxt   = S_WRITE;
        end
      end
      S_WRITE: if (cfgWrReady) begin
        stb.incWord = 1'b1;
        if (wordLast) stateNxt = S_RESP;
      end
      S_INIT: if (macInitReady) begin
        sessNxt  = 1'b1;
        stateNxt = S_RDREQ;
      end
      S_RDREQ: if (cfgRdReqReady) stateNxt = S_RDDATA;
      S_RDDATA: if (cfgRdValid && !fifoFull) begin
        stb.wrRd     = 1'b1;
        stb.pushFifo = 1'b1;
        stb.incWord  = 1'b1;
        if (wordLast) stateNxt = S_UPD;
      end
      S_UPD: if (macUpdReady) begin
        stb.incBlk = 1'b1;
        if (blkLast) stateNxt = S_RESP;
      end
      S_FIN: if (macFinReady) stateNxt = S_TAG;
      S_TAG: if (macTagValid) begin
        stb.capTag = 1'b1;
        sessNxt    = 1'b0;
        stateNxt   = S_RESP;
      end
      S_RESP:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      statusReg   <= ST_OK;
      sessionOpen <= 1'b0;
      rejBusy     <= 1'b0;
    end else begin
      state       <= stateNxt;
      statusReg   <= statusNxt;
      sessionOpen <= sessNxt;
      rejBusy     <= cmdValid && (state != S_IDLE);
    end
  end

  assign busy          = (state != S_IDLE);
  assign done          = (state == S_RESP);
  assign rspStatus     = statusReg;
  assign cfgWrValid    = (state == S_WRITE);
  assign cfgRdReqValid = (state == S_RDREQ);
  assign cfgRdReady    = (state == S_RDDATA) && !fifoFull;
  assign macInitValid  = (state == S_INIT);
  assign macUpdValid   = (state == S_UPD);
  assign macUpdLast    = (state == S_UPD) && blkLast;
  assign macFinValid   = (state == S_FIN);
endmodule

// File: rtl/frame_attest_ctrl.sv
module frame_attest_ctrl
  import fac_pkg::*;
#(
  parameter int WORD_W      = fac_pkg::WORD_W,
  parameter int FRAME_WORDS = fac_pkg::FRAME_WORDS,
  parameter int BLK_W       = fac_pkg::BLK_W,
  parameter int FRAME_ID_W  = fac_pkg::FRAME_ID_W,
  parameter int MAX_FRAME   = fac_pkg::MAX_FRAME,
  parameter int FIFO_DEPTH  = fac_pkg::FIFO_DEPTH
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [1:0]            cmdOp,
  input  logic [FRAME_ID_W-1:0] cmdFrame,
  input  logic                  payValid,
  input  logic [WORD_W-1:0]     payData,
  output logic                  busy,
  output logic                  rejBusy,
  output logic                  done,
  output logic [1:0]            rspStatus,
  output logic [BLK_W-1:0]      rspTag,
  output logic                  sessionOpen,
  output logic                  cfgWrValid,
  output logic [WORD_W-1:0]     cfgWrData,
  input  logic                  cfgWrReady,
  output logic                  cfgRdReqValid,
  output logic [FRAME_ID_W-1:0] cfgRdFrame,
  input  logic                  cfgRdReqReady,
  input  logic                  cfgRdValid,
  input  logic [WORD_W-1:0]     cfgRdData,
  output logic                  cfgRdReady,
  output logic                  fifoValid,
  output logic [WORD_W-1:0]     fifoData,
  input  logic                  fifoReady,
  output logic                  macInitValid,
  input  logic                  macInitReady,
  output logic                  macUpdValid,
  output logic [BLK_W-1:0]      macUpdData,
  output logic                  macUpdLast,
  input  logic                  macUpdReady,
  output logic                  macFinValid,
  input  logic                  macFinReady,
  input  logic                  macTagValid,
  input  logic [BLK_W-1:0]      macTag
);
  strobeT stb;
  logic   wordLast, blkLast, fifoFull;

  fac_control #(.FRAME_ID_W(FRAME_ID_W), .MAX_FRAME(MAX_FRAME)) u_ctrl (
    .clk, .rstN, .cmdValid, .cmdOp, .cmdFrame, .payValid,
    .wordLast, .blkLast, .fifoFull,
    .cfgWrReady, .cfgRdReqReady, .cfgRdValid,
    .macInitReady, .macUpdReady, .macFinReady, .macTagValid,
    .stb, .busy, .rejBusy, .done, .rspStatus, .sessionOpen,
    .cfgWrValid, .cfgRdReqValid, .cfgRdReady,
    .macInitValid, .macUpdValid, .macUpdLast, .macFinValid
  );

  fac_datapath #(
    .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS), .BLK_W(BLK_W),
    .FRAME_ID_W(FRAME_ID_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_dp (
    .clk, .rstN, .stb, .cmdFrame, .payData, .cfgRdData, .macTag, .fifoReady,
    .wordLast, .blkLast, .fifoFull, .cfgWrData, .macUpdData,
    .frameReg(cfgRdFrame), .tagReg(rspTag), .fifoValid, .fifoData
  );
endmodule

// File: rtl/fac_checker.sv
module fac_checker #(
  parameter int WORD_W     = fac_pkg::WORD_W,
  parameter int BLK_W      = fac_pkg::BLK_W,
  parameter int FRAME_ID_W = fac_pkg::FRAME_ID_W,
  parameter int MAX_FRAME  = fac_pkg::MAX_FRAME
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cmdValid,
  input logic                  busy,
  input logic                  rejBusy,
  input logic                  sessionOpen,
  input logic                  cfgWrValid,
  input logic [WORD_W-1:0]     cfgWrData,
  input logic                  cfgWrReady,
  input logic                  cfgRdReqValid,
  input logic [FRAME_ID_W-1:0] cfgRdFrame,
  input logic                  macInitValid,
  input logic                  macUpdValid,
  input logic [BLK_W-1:0]      macUpdData,
  input logic                  macUpdLast,
  input logic                  macUpdReady,
  input logic                  macFinValid
);
  assert_reject_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && busy |=> rejBusy);

  assert_init_closed_R5: assert property (@(posedge clk) disable iff (!rstN)
    macInitValid |-> !sessionOpen);

  assert_fin_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    macFinValid |-> sessionOpen);

  assert_frame_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdReqValid |-> (cfgRdFrame <= FRAME_ID_W'(MAX_FRAME)));

  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrValid && !cfgWrReady |=> cfgWrValid && $stable(cfgWrData));

  assert_upd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    macUpdValid && !macUpdReady |=> macUpdValid && $stable(macUpdData) && $stable(macUpdLast));

  assert_one_port_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cfgWrValid, cfgRdReqValid, macInitValid, macUpdValid, macFinValid}));
endmodule

bind frame_attest_ctrl fac_checker #(
  .WORD_W(WORD_W), .BLK_W(BLK_W), .FRAME_ID_W(FRAME_ID_W), .MAX_FRAME(MAX_FRAME)
) u_fac_checker (
  .clk, .rstN, .cmdValid, .busy, .rejBusy, .sessionOpen,
  .cfgWrValid, .cfgWrData, .cfgWrReady, .cfgRdReqValid, .cfgRdFrame,
  .macInitValid, .macUpdValid, .macUpdData, .macUpdLast, .macUpdReady, .macFinValid
);

// File: tb/test_frame_attest_ctrl.sv
module test_frame_attest_ctrl;
  localparam int FW = 81;
  localparam int NB = 21;
  localparam int MAXF = 28487;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [14:0] cmdFrame = '0;
  logic payValid = 1'b0;
  logic [31:0] payData = '0;
  logic busy, rejBusy, done, sessionOpen;
  logic [1:0] rspStatus;
  logic [127:0] rspTag;
  logic cfgWrValid, cfgRdReqValid, cfgRdReady, fifoValid;
  logic [31:0] cfgWrData, fifoData, cfgRdData;
  logic [14:0] cfgRdFrame;
  logic cfgWrReady = 1'b0, cfgRdReqReady = 1'b0, cfgRdValid = 1'b0, fifoReady = 1'b0;
  logic macInitReady = 1'b0, macUpdReady = 1'b0, macFinReady = 1'b0, macTagValid = 1'b0;
  logic macInitValid, macUpdValid, macUpdLast, macFinValid;
  logic [127:0] macUpdData;
  logic [127:0] macTag = '0;

  frame_attest_ctrl i_frame_attest_ctrl (
    .clk, .rstN, .cmdValid, .cmdOp, .cmdFrame, .payValid, .payData,
    .busy, .rejBusy, .done, .rspStatus, .rspTag, .sessionOpen,
    .cfgWrValid, .cfgWrData, .cfgWrReady, .cfgRdReqValid, .cfgRdFrame, .cfgRdReqReady,
    .cfgRdValid, .cfgRdData, .cfgRdReady, .fifoValid, .fifoData, .fifoReady,
    .macInitValid, .macInitReady, .macUpdValid, .macUpdData, .macUpdLast, .macUpdReady,
    .macFinValid, .macFinReady, .macTagValid, .macTag
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rdWord(int f, int i);
    return (32'(f) * 32'h0001_0003) ^ (32'(i) * 32'h0100_0193) ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [127:0] expBlk(int f, int b);
    logic [127:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (4*b + k < FW) r[32*k +: 32] = rdWord(f, 4*b + k);
    return r;
  endfunction

  // ---------------- side models (drive on posedge with NBA) ----------------
  bit rdActive = 0;
  int rdIdx = 0, rdF = 0, rdN;
  int tagDelay = 0;
  assign cfgRdData = rdWord(rdF, rdIdx);

  always @(posedge clk) begin
    cfgWrReady    <= ($urandom % 4) != 0;
    cfgRdReqReady <= ($urandom % 3) != 0;
    macInitReady  <= ($urandom % 3) != 0;
    macUpdReady   <= ($urandom % 3) != 0;
    macFinReady   <= ($urandom % 3) != 0;
    fifoReady     <= ($urandom % 4) != 0;
    if (!rstN) begin
      rdActive <= 0; cfgRdValid <= 0; tagDelay <= 0; macTagValid <= 0;
    end else begin
      if (cfgRdReqValid && cfgRdReqReady) begin
        rdActive <= 1; rdIdx <= 0; rdF <= int'(cfgRdFrame); cfgRdValid <= 0;
      end else if (rdActive) begin
        rdN = rdIdx + ((cfgRdValid && cfgRdReady) ? 1 : 0);
        rdIdx <= rdN;
        if (rdN >= FW) begin rdActive <= 0; cfgRdValid <= 0; end
        else cfgRdValid <= ($urandom % 3) != 0;
      end
      if (macFinValid && macFinReady) tagDelay <= 3;
      else if (tagDelay > 0) begin
        tagDelay <= tagDelay - 1;
        if (tagDelay == 1) begin
          macTagValid <= 1;
          macTag <= {$urandom, $urandom, $urandom, $urandom};
        end
      end else macTagValid <= 0;
    end
  end

  // ---------------- monitors (negedge) ----------------
  int initCnt = 0, rdReqCnt = 0, finCnt = 0, wrCnt = 0, fifoCnt = 0, blkCnt = 0;
  int lastFrame = -1;
  logic [31:0] wrSeen [256];
  logic [31:0] fifoSeen [256];
  logic [127:0] blkSeen [64];
  logic lastSeen [64];
  logic [127:0] seenTag = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (macInitValid && macInitReady) initCnt++;
      if (cfgRdReqValid && cfgRdReqReady) begin rdReqCnt++; lastFrame = int'(cfgRdFrame); end
      if (macFinValid && macFinReady) finCnt++;
      if (cfgWrValid && cfgWrReady) begin if (wrCnt < 256) wrSeen[wrCnt] = cfgWrData; wrCnt++; end
      if (fifoValid && fifoReady) begin if (fifoCnt < 256) fifoSeen[fifoCnt] = fifoData; fifoCnt++; end
      if (macUpdValid && macUpdReady) begin
        if (blkCnt < 64) begin blkSeen[blkCnt] = macUpdData; lastSeen[blkCnt] = macUpdLast; end
        blkCnt++;
      end
      if (macTagValid) seenTag = macTag;
    end
  end

  task automatic clearMon();
    initCnt = 0; rdReqCnt = 0; finCnt = 0; wrCnt = 0; fifoCnt = 0; blkCnt = 0; lastFrame = -1;
  endtask

  task automatic sendCmd(logic [1:0] op, int fr);
    @(negedge clk);
    cmdValid = 1; cmdOp = op; cmdFrame = 15'(fr);
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic waitDone(output logic [1:0] st);
    st = 'x;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin st = rspStatus; break; end
      @(negedge clk);
    end
  endtask

  task automatic drainFifo();
    for (int i = 0; i < 1000; i++) begin
      if (!fifoValid) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic doRead(int fr, int expInit, string tag);
    logic [1:0] st;
    bit okF = 1, okB = 1, okL = 1;
    clearMon();
    sendCmd(2'd1, fr);
    waitDone(st);
    drainFifo();
    chk(st == 2'd0, "R3", {tag, " status"}, 128'(st), 128'd0);
    chk(rdReqCnt == 1 && lastFrame == fr, "R3", {tag, " read frame"}, 128'(lastFrame), 128'(fr));
    for (int i = 0; i < FW; i++) if (fifoSeen[i] !== rdWord(fr, i)) okF = 0;
    chk(okF && fifoCnt == FW, "R3", {tag, " fifo words"}, 128'(fifoCnt), 128'(FW));
    for (int b = 0; b < NB; b++) begin
      if (blkSeen[b] !== expBlk(fr, b)) okB = 0;
      if (lastSeen[b] !== (b == NB - 1)) okL = 0;
    end
    chk(okB && blkCnt == NB, "R4", {tag, " blocks R12"}, 128'(blkCnt), 128'(NB));
    chk(okL, "R4", {tag, " last flag"}, 128'(okL), 128'd1);
    chk(initCnt == expInit && sessionOpen, "R5", {tag, " init count"}, 128'(initCnt), 128'(expInit));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] st;
    logic [31:0] pay [FW];
    bit ok;
    int fr, rep;
    void'($urandom(32'd20250));
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !rejBusy && !sessionOpen, "R1", "idle flags", {busy, done, rejBusy, sessionOpen}, 0);
    chk(!cfgWrValid && !cfgRdReqValid && !macInitValid && !macUpdValid && !macFinValid && !fifoValid,
        "R1", "valids low", 0, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R7 checksum without session
    clearMon();
    sendCmd(2'd2, 0);
    waitDone(st);
    repeat (6) @(negedge clk);
    chk(st == 2'd1 && finCnt == 0, "R7", "no-session checksum", 128'(st), 128'd1);

    // R2 write
    clearMon();
    for (int i = 0; i < FW; i++) pay[i] = $urandom;
    pay[0] = 32'h0042_1A00;
    sendCmd(2'd0, 0);
    for (int i = 0; i < FW; i++) begin
      while (($urandom % 4) == 0) @(negedge clk);
      payValid = 1; payData = pay[i];
      @(negedge clk);
      payValid = 0;
    end
    payValid = 1; payData = 32'hDEAD_BEEF;  // extra word outside the load phase
    @(negedge clk);
    payValid = 0;
    waitDone(st);
    ok = 1;
    for (int i = 0; i < FW; i++) if (wrSeen[i] !== pay[i]) ok = 0;
    chk(st == 2'd0, "R2", "write status", 128'(st), 0);
    chk(ok && wrCnt == FW, "R2", "write words in order R11", 128'(wrCnt), 128'(FW));
    chk(!sessionOpen, "R2", "write leaves session closed", 128'(sessionOpen), 0);

    // R8 boundary accepted, opens session
    doRead(MAXF, 1, "R8 frame 28487");

    // R8 out of range
    clearMon();
    sendCmd(2'd1, MAXF + 1);
    waitDone(st);
    repeat (6) @(negedge clk);
    chk(st == 2'd2 && rdReqCnt == 0 && blkCnt == 0 && initCnt == 0, "R8", "frame 28488 refused",
        128'(st), 128'd2);

    // R12 repeat, R5 no further init, random frames
    fr = $urandom_range(0, MAXF);
    doRead(fr, 0, "R12 first");
    doRead(fr, 0, "R12 repeat");
    for (int n = 0; n < 5; n++) doRead($urandom_range(0, MAXF), 0, "R5 random");
    doRead(0, 0, "R3 frame 0");

    // R9 busy reject
    clearMon();
    sendCmd(2'd1, 77);
    sendCmd(2'd0, 0);
    chk(rejBusy == 1'b1, "R9", "rejBusy pulse", 128'(rejBusy), 1);
    @(negedge clk);
    chk(rejBusy == 1'b0, "R9", "rejBusy one cycle", 128'(rejBusy), 0);
    waitDone(st);
    drainFifo();
    repeat (10) @(negedge clk);
    chk(!busy && wrCnt == 0 && rdReqCnt == 1, "R9", "refused cmd not run", 128'(wrCnt), 0);

    // R10 reserved op
    clearMon();
    sendCmd(2'd3, 5);
    waitDone(st);
    repeat (4) @(negedge clk);
    chk(st == 2'd3 && rdReqCnt == 0 && sessionOpen, "R10", "reserved op", 128'(st), 128'd3);

    // R6 checksum with session
    clearMon();
    sendCmd(2'd2, 0);
    waitDone(st);
    @(negedge clk);
    chk(st == 2'd0 && finCnt == 1, "R6", "finalize once", 128'(finCnt), 1);
    chk(rspTag == seenTag, "R6", "tag returned", rspTag, seenTag);
    chk(!sessionOpen, "R6", "session closed", 128'(sessionOpen), 0);

    // R5 new session after close
    doRead($urandom_range(0, MAXF), 1, "R5 reopen");

    // random command mix
    for (int n = 0; n < 4; n++) begin
      rep = int'($urandom % 2);
      if (rep == 0) begin
        clearMon();
        sendCmd(2'd2, 0);
        waitDone(st);
        @(negedge clk);
        chk(st == 2'd0 && !sessionOpen && finCnt == 1, "R6", "mix checksum", 128'(st), 0);
        doRead($urandom_range(0, MAXF), 1, "R5 mix reopen");
      end else doRead($urandom_range(0, MAXF), 0, "R12 mix");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule